// File: doc/BRIEF.md
# Exhaustive PLL Divider Pair Search

This block picks the feedback and reference divider settings of a frequency synthesizer. It takes a requested pixel clock in hundredths of a megahertz and returns the divider pair whose synthesized frequency lies closest to the request. After limiting the request to the synthesizer's legal band, the block picks a power-of-two post-divide exponent. It then tries every reference divider value and, for each one, every feedback divider value. It keeps the first pair that reaches the smallest absolute error. The answer is packed into a 16-bit programming word.

A request enters on a valid/ready handshake. The block takes one request at a time: `in_ready` is high only when the engine is idle. While `in_ready` is low, an upstream source that holds `in_valid` high waits, and its target is not looked at. The result comes back as a one-cycle `out_done` pulse. `out_word` holds its value until the next pulse. A single shared sequential divider works out the scaled target and then each candidate frequency, one per pass, so a search takes roughly (candidates + 1) x (DIV_W + 2) cycles.

Top module: `pll_mn_search`

## Requirements
- R1: `in_ready` is high only when the engine is idle. A request is taken on a cycle with `in_valid` and `in_ready` both high, and `in_target` is sampled on that cycle. `in_ready` stays low from acceptance through the `out_done` cycle. Inputs offered while it is low have no effect on the result.
- R2: A target of 0 produces `out_word` = 16'h00E0, with `out_done` high in the cycle right after acceptance.
- R3: A nonzero target is limited to the band [8000, 15938]. Any target below 8000 gives the same word as 8000, and any target above 15938 gives the same word as 15938.
- R4: The comparison value is floor(limited target x 256 / 100), which has 8 fractional bits.
- R5: The exponent k is the number of times the limited target must be doubled before it reaches at least 64000. This is 3 for every value in the band.
- R6: Each candidate frequency is floor(938356 x (n + 8) / ((256 << k) x (m + 2))). Its error is the absolute difference from the R4 value. The m value runs from MIN_M to MAX_M in the outer loop (defaults 2 and 30), and n runs from MIN_N to MAX_N in the inner loop (defaults 35 and 247), both ascending.
- R7: A candidate replaces the saved best only when its error is strictly smaller. The saved error starts at all ones, so on a tie the earliest pair in scan order wins.
- R8: The word is (n << 8) + (k << 6) + m. This puts n in bits 15:8, k in bits 7:6 and m in bits 5:0.
- R9: `out_done` is a single-cycle pulse. `out_word` changes only in a cycle in which `out_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Engine idle, request will be taken |
| in_target | input | TGT_W (16) | Requested frequency in 0.01 MHz steps |
| out_done | output | 1 | One-cycle result pulse |
| out_word | output | WORD_W (16) | Packed divider programming word |

## Verification
A wrong internal state shows at the ports only as a wrong word or a wrong pulse time, and only at the end of a search. For that reason, every result is compared in full with an arithmetic model of the whole scan. A corrupted scaled target or a skipped candidate moves the chosen pair at the next `out_done`. A broken tie rule appears only on a target where two pairs share the minimum error, so the bench looks for such a target itself. A handshake fault shows within one cycle as `in_ready` high during a search, or as a result that follows a target offered while busy.

// File: rtl/pll_mn_search_pkg.sv
package pll_mn_search_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SCALE_GO,
    S_SCALE_WAIT,
    S_CAND_GO,
    S_CAND_WAIT,
    S_PACK,
    S_RESP
  } srch_state_t;

  localparam int M_FIELD_W = 6;
  localparam int N_FIELD_W = 8;
  localparam int K_FIELD_W = 2;

endpackage

// File: rtl/pll_div_seq.sv
module pll_div_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q;
  logic [W-1:0]     quo_q;
  logic [W-1:0]     dsr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W:0]       shifted;
  logic             fits;

  assign shifted  = {rem_q, quo_q[W-1]};
  assign fits     = shifted >= {1'b0, dsr_q};
  assign quotient = quo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (start) begin
      rem_q <= '0;
      quo_q <= dividend;
      dsr_q <= divisor;
      cnt_q <= CNT_W'(W);
      done  <= 1'b0;
    end else if (cnt_q != '0) begin
      if (fits) begin
        rem_q <= W'(shifted - {1'b0, dsr_q});
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
      cnt_q <= cnt_q - 1'b1;
      done  <= (cnt_q == CNT_W'(1));
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/pll_cand_gen.sv
module pll_cand_gen #(
  parameter int MIN_M = 2,
  parameter int MAX_M = 30,
  parameter int MIN_N = 35,
  parameter int MAX_N = 247,
  parameter int M_W   = 6,
  parameter int N_W   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init,
  input  logic           step,
  output logic [M_W-1:0] m,
  output logic [N_W-1:0] n,
  output logic           last
);
  logic n_wrap;

  assign n_wrap = (n == N_W'(MAX_N));
  assign last   = n_wrap && (m == M_W'(MAX_M));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m <= M_W'(MIN_M);
      n <= N_W'(MIN_N);
    end else if (init) begin
      m <= M_W'(MIN_M);
      n <= N_W'(MIN_N);
    end else if (step) begin
      if (n_wrap) begin
        n <= N_W'(MIN_N);
        m <= m + 1'b1;
      end else begin
        n <= n + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_best_keep.sv
module pll_best_keep #(
  parameter int E_W = 32,
  parameter int M_W = 6,
  parameter int N_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           offer,
  input  logic [E_W-1:0] err,
  input  logic [M_W-1:0] m,
  input  logic [N_W-1:0] n,
  output logic [M_W-1:0] best_m,
  output logic [N_W-1:0] best_n
);
  logic [E_W-1:0] best_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_err <= '1;
      best_m   <= '0;
      best_n   <= '0;
    end else if (clear) begin
      best_err <= '1;
      best_m   <= '0;
      best_n   <= '0;
    end else if (offer && (err < best_err)) begin
      best_err <= err;
      best_m   <= m;
      best_n   <= n;
    end
  end
endmodule

// File: rtl/pll_mn_search.sv
module pll_mn_search #(
  parameter int TGT_W    = 16,
  parameter int WORD_W   = 16,
  parameter int DIV_W    = 32,
  parameter int F_LO     = 8000,
  parameter int F_HI     = 15938,
  parameter int REF_Q16  = 938356,
  parameter int N_OFS    = 8,
  parameter int M_OFS    = 2,
  parameter int MIN_M    = 2,
  parameter int MAX_M    = 30,
  parameter int MIN_N    = 35,
  parameter int MAX_N    = 247,
  parameter int ZERO_WORD = 224
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TGT_W-1:0]  in_target,
  output logic              out_done,
  output logic [WORD_W-1:0] out_word
);
  import pll_mn_search_pkg::*;

  localparam int M_W      = M_FIELD_W;
  localparam int N_W      = N_FIELD_W;
  localparam int K_W      = K_FIELD_W;
  localparam int K_LIMIT  = (1 << K_W) - 1;
  localparam int VCO_LO   = F_LO * 8;
  localparam int WIDE_W   = TGT_W + K_LIMIT + 1;
  localparam int N_SHIFT  = M_W + K_W;

  srch_state_t      state;
  logic [TGT_W-1:0] lim_q;
  logic [K_W-1:0]   k_q;
  logic [DIV_W-1:0] scaled_q;
  logic [TGT_W-1:0] lim_in;
  logic [K_W-1:0]   k_in;
  logic             accept;

  logic             div_start;
  logic [DIV_W-1:0] div_num;
  logic [DIV_W-1:0] div_den;
  logic             div_done;
  logic [DIV_W-1:0] div_quo;

  logic             gen_init;
  logic             gen_step;
  logic [M_W-1:0]   cm;
  logic [N_W-1:0]   cn;
  logic             clast;

  logic             best_offer;
  logic [DIV_W-1:0] cand_err;
  logic [M_W-1:0]   best_m;
  logic [N_W-1:0]   best_n;

  function automatic logic [TGT_W-1:0] band_limit(input logic [TGT_W-1:0] f);
    if (f < TGT_W'(F_LO))      return TGT_W'(F_LO);
    else if (f > TGT_W'(F_HI)) return TGT_W'(F_HI);
    else                       return f;
  endfunction

  function automatic logic [K_W-1:0] doublings(input logic [TGT_W-1:0] f);
    logic [WIDE_W-1:0] w;
    logic [K_W-1:0]    k;
    w = WIDE_W'(f);
    k = '0;
    for (int i = 0; i < K_LIMIT; i++) begin
      if (w < WIDE_W'(VCO_LO)) begin
        w = w << 1;
        k = k + 1'b1;
      end
    end
    return k;
  endfunction

  assign lim_in   = band_limit(in_target);
  assign k_in     = doublings(lim_in);
  assign in_ready = (state == S_IDLE);
  assign out_done = (state == S_RESP);
  assign accept   = in_valid && in_ready;

  // One divider shared between the scaling pass and every candidate pass
  assign div_start = (state == S_SCALE_GO) || (state == S_CAND_GO);
  always_comb begin
    if (state == S_SCALE_GO) begin
      div_num = DIV_W'(lim_q) << 8;
      div_den = DIV_W'(100);
    end else begin
      div_num = DIV_W'(REF_Q16) * (DIV_W'(cn) + DIV_W'(N_OFS));
      div_den = (DIV_W'(256) << k_q) * (DIV_W'(cm) + DIV_W'(M_OFS));
    end
  end

  pll_div_seq #(.W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_num),
    .divisor  (div_den),
    .done     (div_done),
    .quotient (div_quo)
  );

  assign gen_init   = (state == S_SCALE_WAIT) && div_done;
  assign best_offer = (state == S_CAND_WAIT) && div_done;
  assign gen_step   = best_offer && !clast;
  assign cand_err   = (div_quo > scaled_q) ? (div_quo - scaled_q) : (scaled_q - div_quo);

  pll_cand_gen #(
    .MIN_M (MIN_M), .MAX_M (MAX_M), .MIN_N (MIN_N), .MAX_N (MAX_N),
    .M_W   (M_W),   .N_W   (N_W)
  ) u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (gen_init),
    .step  (gen_step),
    .m     (cm),
    .n     (cn),
    .last  (clast)
  );

  pll_best_keep #(.E_W(DIV_W), .M_W(M_W), .N_W(N_W)) u_best (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (gen_init),
    .offer  (best_offer),
    .err    (cand_err),
    .m      (cm),
    .n      (cn),
    .best_m (best_m),
    .best_n (best_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      lim_q    <= '0;
      k_q      <= '0;
      scaled_q <= '0;
      out_word <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            if (in_target == '0) begin
              out_word <= WORD_W'(ZERO_WORD);
              state    <= S_RESP;
            end else begin
              lim_q <= lim_in;
              k_q   <= k_in;
              state <= S_SCALE_GO;
            end
          end
        end
        S_SCALE_GO:  state <= S_SCALE_WAIT;
        S_SCALE_WAIT: begin
          if (div_done) begin
            scaled_q <= div_quo;
            state    <= S_CAND_GO;
          end
        end
        S_CAND_GO:   state <= S_CAND_WAIT;
        S_CAND_WAIT: begin
          if (div_done) state <= clast ? S_PACK : S_CAND_GO;
        end
        S_PACK: begin
          out_word <= (WORD_W'(best_n) << N_SHIFT) + (WORD_W'(k_q) << M_W) + WORD_W'(best_m);
          state    <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_mn_search_chk.sv
module pll_mn_search_chk #(
  parameter int TGT_W     = 16,
  parameter int WORD_W    = 16,
  parameter int MIN_M     = 2,
  parameter int MAX_M     = 30,
  parameter int MIN_N     = 35,
  parameter int MAX_N     = 247,
  parameter int ZERO_WORD = 224
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [TGT_W-1:0]  in_target,
  input logic              out_done,
  input logic [WORD_W-1:0] out_word
);
  logic real_res;
  assign real_res = out_done && (out_word != WORD_W'(ZERO_WORD));

  a_r2_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_target == '0) |=> (out_done && out_word == WORD_W'(ZERO_WORD)));

  a_r1_busy_during_done: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> !in_ready);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_word) |-> out_done);

  a_r5_k_field: assert property (@(posedge clk) disable iff (!rst_n)
    real_res |-> (out_word[7:6] == 2'd3));

  a_r8_m_field: assert property (@(posedge clk) disable iff (!rst_n)
    real_res |-> (out_word[5:0] >= 6'(MIN_M) && out_word[5:0] <= 6'(MAX_M)));

  a_r8_n_field: assert property (@(posedge clk) disable iff (!rst_n)
    real_res |-> (out_word[15:8] >= 8'(MIN_N) && out_word[15:8] <= 8'(MAX_N)));
endmodule

bind pll_mn_search pll_mn_search_chk #(
  .TGT_W (TGT_W), .WORD_W (WORD_W), .MIN_M (MIN_M), .MAX_M (MAX_M),
  .MIN_N (MIN_N), .MAX_N (MAX_N), .ZERO_WORD (ZERO_WORD)
) u_chk (
  .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
  .in_target (in_target), .out_done (out_done), .out_word (out_word)
);

// File: tb/pll_mn_search_test.sv
module pll_mn_search_test;
  localparam int TB_MIN_M = 2;
  localparam int TB_MAX_M = 4;
  localparam int TB_MIN_N = 216;
  localparam int TB_MAX_N = 247;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_target = '0;
  logic        out_done;
  logic [15:0] out_word;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pll_mn_search #(
    .MIN_M (TB_MIN_M), .MAX_M (TB_MAX_M), .MIN_N (TB_MIN_N), .MAX_N (TB_MAX_N)
  ) uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_target (in_target), .out_done (out_done), .out_word (out_word)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint cand_f(longint m, longint n, longint k);
    return (64'd938356 * (n + 8)) / ((64'd256 << k) * (m + 2));
  endfunction

  function automatic longint scaled(longint t, output longint k);
    longint c;
    longint w;
    c = (t < 8000) ? 8000 : ((t > 15938) ? 15938 : t);
    w = c;
    k = 0;
    while (w < 64000) begin
      w = w * 2;
      k++;
    end
    return (c * 256) / 100;
  endfunction

  function automatic logic [15:0] model(longint t);
    longint k, lng, best, bm, bn, d, f;
    if (t == 0) return 16'h00E0;
    lng = scaled(t, k);
    best = 64'hFFFF_FFFF;
    bm = 0;
    bn = 0;
    for (longint m = TB_MIN_M; m <= TB_MAX_M; m++)
      for (longint n = TB_MIN_N; n <= TB_MAX_N; n++) begin
        f = cand_f(m, n, k);
        d = (f > lng) ? f - lng : lng - f;
        if (d < best) begin
          best = d; bm = m; bn = n;
        end
      end
    return 16'((bn << 8) + (k << 6) + bm);
  endfunction

  function automatic int tie_count(longint t);
    longint k, lng, best, d, f;
    int cnt;
    lng = scaled(t, k);
    best = 64'hFFFF_FFFF;
    cnt = 0;
    for (longint m = TB_MIN_M; m <= TB_MAX_M; m++)
      for (longint n = TB_MIN_N; n <= TB_MAX_N; n++) begin
        f = cand_f(m, n, k);
        d = (f > lng) ? f - lng : lng - f;
        if (d < best) begin best = d; cnt = 1; end
        else if (d == best) cnt++;
      end
    return cnt;
  endfunction

  task automatic run(input int t, input bit poke, input int alt,
                     output logic [15:0] w, output int lat);
    int rdy_hi;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid  = 1'b1;
    in_target = 16'(t);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    rdy_hi = 0;
    while (!out_done && lat < 20000) begin
      if (in_ready) rdy_hi++;
      if (poke) begin
        in_valid  = 1'b1;
        in_target = 16'(alt);
      end
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    w = out_word;
    check(rdy_hi == 0, "R1 ready low while searching", rdy_hi, 0);
    check(in_ready == 1'b0, "R1 ready low in done cycle", in_ready, 0);
    @(negedge clk);
    check(out_done == 1'b0, "R9 done lasts one cycle", out_done, 0);
    check(out_word == w, "R9 word holds after done", out_word, w);
  endtask

  task automatic run_cmp(input int t, input string req);
    logic [15:0] w;
    logic [15:0] e;
    int lat;
    run(t, 1'b0, 0, w, lat);
    e = model(t);
    check(w == e, req, w, e);
    if (t != 0) begin
      check(w[7:6] == 2'd3, "R5 k field", w[7:6], 3);
      check(w[5:0] >= 6'(TB_MIN_M) && w[5:0] <= 6'(TB_MAX_M), "R8 m field", w[5:0], TB_MIN_M);
      check(w[15:8] >= 8'(TB_MIN_N) && w[15:8] <= 8'(TB_MAX_N), "R8 n field", w[15:8], TB_MIN_N);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] w;
    logic [15:0] wa;
    int lat;
    int tie_t;

    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
    check(out_done == 1'b0, "R9 no done in reset", out_done, 0);
    check(out_word == 16'h0, "R9 word zero in reset", out_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

    // R2 zero target, immediate answer
    run(0, 1'b0, 0, w, lat);
    check(w == 16'h00E0, "R2 zero word", w, 16'h00E0);
    check(lat == 1, "R2 done right after accept", lat, 1);

    // R4 R6 main sweep across the band
    for (int t = 8000; t <= 15938; t += 900) run_cmp(t, "R4 R6 sweep word");
    run_cmp(8000, "R6 low edge");
    run_cmp(8001, "R4 low edge plus one");
    run_cmp(15937, "R4 high edge minus one");
    run_cmp(15938, "R6 high edge");

    // R3 clamping
    run(1, 1'b0, 0, w, lat);
    check(w == model(8000), "R3 below band clamps", w, model(8000));
    run(7999, 1'b0, 0, wa, lat);
    check(wa == w, "R3 7999 same as 8000", wa, w);
    run(15939, 1'b0, 0, w, lat);
    check(w == model(15938), "R3 above band clamps", w, model(15938));
    run(65535, 1'b0, 0, wa, lat);
    check(wa == w, "R3 65535 same as 15938", wa, w);

    // R1 targets offered while busy are ignored
    run(12345, 1'b1, 0, w, lat);
    check(w == model(12345), "R1 busy input ignored", w, model(12345));
    run(9100, 1'b1, 15000, w, lat);
    check(w == model(9100), "R1 busy input ignored 2", w, model(9100));

    // R7 tie: earliest pair in scan order keeps the win
    tie_t = -1;
    for (int t = 8000; t <= 15938 && tie_t < 0; t++)
      if (tie_count(t) > 1) tie_t = t;
    if (tie_t > 0) run_cmp(tie_t, "R7 tie keeps earliest pair");
    else run_cmp(11111, "R7 strict improvement");

    // R8 packing of a known word
    run(10000, 1'b0, 0, w, lat);
    check(w == model(10000), "R8 packed word", w, model(10000));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule